// File: doc/BRIEF.md
# Serial Audio Layout Detector and I2S Adapter

This block sits on an incoming three-wire serial audio stream (bit clock, word select, data) and works out which of two word layouts the source uses. It runs directly on the incoming bit clock and measures, on each rising bit-clock edge, how many bit clocks pass between successive word-select transitions. Half-frames of 32 bit clocks are taken as the standard I2S layout; half-frames of 24 bit clocks (48 per frame) are taken as the Sony right-justified layout.

Once a layout is known, the block raises a registered valid flag and a layout flag, lights one of two indicator outputs, and adapts the stream. For the Sony layout, word select is delayed by a fixed number of extra bit clocks (seven by default) relative to data, turning the stream into standard I2S timing. For the standard layout, that extra delay is bypassed. Downstream delay chains can use the layout flag to pick their taps and to decide on clock inversion. The bit clock is forwarded unchanged.

Top module: `fad_top`

## Requirements
- R1: While `rst_n` is low, `fmt_valid`, `fmt_sony`, `led_i2s`, `led_sony`, `ws_out` and `data_out` are all low, and asserting `rst_n` clears them at once without a clock.
- R2: A half-frame is the count of BCK rising edges from one sampled WS transition to the next. After a first transition, two successive half-frames of 32 give `fmt_valid`=1 and `fmt_sony`=0 (standard I2S).
- R3: Two successive half-frames of 24 give `fmt_valid`=1 and `fmt_sony`=1 (Sony layout).
- R4: Once decided, the layout flag changes only when two successive half-frames agree on the other layout. A single differing half-frame leaves it unchanged.
- R5: A half-frame of any other length leaves the current decision unchanged and discards any pending candidate, so the next recognised half-frame starts a new pair.
- R6: The decision is registered on the BCK rising edge that samples the WS transition closing the second agreeing half-frame. `fmt_valid` is low just before that edge and high right after it.
- R7: If no WS transition is sampled for 256 BCK rising edges, the block returns to undecided. `fmt_valid` and `fmt_sony` go low, and a fresh first transition plus two agreeing half-frames are needed again.
- R8: `led_i2s` = `fmt_valid` & !`fmt_sony` and `led_sony` = `fmt_valid` & `fmt_sony`. They are never high together.
- R9: `data_out` after BCK rising edge n equals `data_in` as sampled at edge n-6 (WS_DELAY stages) in every mode. `ws_out` has that same latency when undecided or in the standard layout (`fmt_sony`=0). It equals `ws_in` sampled at edge n-13 (2*WS_DELAY stages) when `fmt_sony`=1.
- R10: `bck_out` follows `bck` with no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck | input | 1 | Incoming bit clock; clocks all logic on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ws_in | input | 1 | Incoming word select |
| data_in | input | 1 | Incoming serial data |
| fmt_valid | output | 1 | High once a layout has been decided |
| fmt_sony | output | 1 | 1 = Sony right-justified, 0 = standard I2S or undecided |
| led_i2s | output | 1 | Indicator for the standard layout |
| led_sony | output | 1 | Indicator for the Sony layout |
| ws_out | output | 1 | Adapted word select |
| data_out | output | 1 | Data delayed to stay aligned with the adapted word select |
| bck_out | output | 1 | Forwarded bit clock |

## Verification
The hardest situations to reach are a layout change and the loss of a decision. In both, the outcome depends on a history of several half-frames and not on the current input. The stimulus walks a table of word-select patterns. The first transition of each row closes the previous row's last half-frame, so rows are chained to build single mismatches, unknown lengths and agreeing pairs in a known order. Word select is then held still past the 256-edge limit, after a count of edges since the last transition has been tracked to sample on both sides of it. The exact decision edge is probed after a fresh reset by checking just before and just after the edge that samples the third transition.

// File: rtl/fad_pkg.sv
package fad_pkg;
  typedef enum logic [1:0] {
    LEN_OTHER = 2'd0,
    LEN_I2S   = 2'd1,
    LEN_SONY  = 2'd2
  } len_class_e;
endpackage

// File: rtl/fad_rst_sync.sv
module fad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fad_detector.sv
module fad_detector
  import fad_pkg::*;
#(
  parameter int I2S_HALF  = 32,
  parameter int SONY_HALF = 24,
  parameter int TIMEOUT   = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws,
  output logic valid,
  output logic sony
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          ws_q;
  logic          seen_q,    seen_d;
  logic [CW-1:0] cnt_q,     cnt_d;
  len_class_e    cand_q,    cand_d;
  logic          cand_ok_q, cand_ok_d;
  logic          valid_q,   valid_d;
  logic          sony_q,    sony_d;
  logic          ws_edge;
  len_class_e    len_cls;

  assign ws_edge = ws ^ ws_q;

  always_comb begin
    if (cnt_q == CW'(I2S_HALF))       len_cls = LEN_I2S;
    else if (cnt_q == CW'(SONY_HALF)) len_cls = LEN_SONY;
    else                              len_cls = LEN_OTHER;
  end

  always_comb begin
    seen_d    = seen_q;
    cnt_d     = cnt_q;
    cand_d    = cand_q;
    cand_ok_d = cand_ok_q;
    valid_d   = valid_q;
    sony_d    = sony_q;
    if (ws_edge) begin
      cnt_d  = CW'(1);
      seen_d = 1'b1;
      if (seen_q) begin
        if (len_cls == LEN_OTHER) begin
          cand_ok_d = 1'b0;
        end else if (cand_ok_q && (cand_q == len_cls)) begin
          valid_d = 1'b1;
          sony_d  = (len_cls == LEN_SONY);
        end else begin
          cand_d    = len_cls;
          cand_ok_d = 1'b1;
        end
      end
    end else if (cnt_q == CW'(TIMEOUT)) begin
      seen_d    = 1'b0;
      cand_ok_d = 1'b0;
      valid_d   = 1'b0;
      sony_d    = 1'b0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q      <= 1'b0;
      seen_q    <= 1'b0;
      cnt_q     <= '0;
      cand_q    <= LEN_OTHER;
      cand_ok_q <= 1'b0;
      valid_q   <= 1'b0;
      sony_q    <= 1'b0;
    end else begin
      ws_q      <= ws;
      seen_q    <= seen_d;
      cnt_q     <= cnt_d;
      cand_q    <= cand_d;
      cand_ok_q <= cand_ok_d;
      valid_q   <= valid_d;
      sony_q    <= sony_d;
    end
  end

  assign valid = valid_q;
  assign sony  = sony_q;
endmodule

// File: rtl/fad_adapt.sv
module fad_adapt #(
  parameter int WS_DELAY = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws,
  input  logic data,
  input  logic sony,
  output logic ws_out,
  output logic data_out
);
  localparam int WS_LEN = 2 * WS_DELAY;

  logic [WS_LEN-1:0]   ws_sr;
  logic [WS_DELAY-1:0] dat_sr;
  logic [WS_LEN-1:0]   ws_sr_d;
  logic [WS_DELAY-1:0] dat_sr_d;

  always_comb begin
    ws_sr_d[0]  = ws;
    dat_sr_d[0] = data;
  end

  for (genvar i = 1; i < WS_LEN; i++) begin : g_ws_stage
    assign ws_sr_d[i] = ws_sr[i-1];
  end

  for (genvar i = 1; i < WS_DELAY; i++) begin : g_dat_stage
    assign dat_sr_d[i] = dat_sr[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_sr  <= '0;
      dat_sr <= '0;
    end else begin
      ws_sr  <= ws_sr_d;
      dat_sr <= dat_sr_d;
    end
  end

  assign ws_out   = sony ? ws_sr[WS_LEN-1] : ws_sr[WS_DELAY-1];
  assign data_out = dat_sr[WS_DELAY-1];
endmodule

// File: rtl/fad_top.sv
module fad_top #(
  parameter int I2S_HALF  = 32,
  parameter int SONY_HALF = 24,
  parameter int TIMEOUT   = 256,
  parameter int WS_DELAY  = 7
) (
  input  logic bck,
  input  logic rst_n,
  input  logic ws_in,
  input  logic data_in,
  output logic fmt_valid,
  output logic fmt_sony,
  output logic led_i2s,
  output logic led_sony,
  output logic ws_out,
  output logic data_out,
  output logic bck_out
);
  logic rst_sync_n;
  logic det_valid;
  logic det_sony;

  fad_rst_sync #(.STAGES(2)) u_rst (
    .clk        (bck),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fad_detector #(
    .I2S_HALF  (I2S_HALF),
    .SONY_HALF (SONY_HALF),
    .TIMEOUT   (TIMEOUT)
  ) u_det (
    .clk   (bck),
    .rst_n (rst_sync_n),
    .ws    (ws_in),
    .valid (det_valid),
    .sony  (det_sony)
  );

  fad_adapt #(.WS_DELAY(WS_DELAY)) u_adapt (
    .clk      (bck),
    .rst_n    (rst_sync_n),
    .ws       (ws_in),
    .data     (data_in),
    .sony     (det_sony),
    .ws_out   (ws_out),
    .data_out (data_out)
  );

  assign fmt_valid = det_valid;
  assign fmt_sony  = det_sony;
  assign led_i2s   = det_valid & ~det_sony;
  assign led_sony  = det_valid & det_sony;
  assign bck_out   = bck;
endmodule

// File: rtl/fad_checker.sv
module fad_checker (
  input logic bck,
  input logic rst_n,
  input logic ws_in,
  input logic fmt_valid,
  input logic fmt_sony,
  input logic led_i2s,
  input logic led_sony
);
  logic       ws_prev;
  logic [9:0] idle;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev <= 1'b0;
      idle    <= '0;
    end else begin
      ws_prev <= ws_in;
      if (ws_in != ws_prev)    idle <= '0;
      else if (idle != 10'h3ff) idle <= idle + 10'd1;
    end
  end

  p_led_excl_r8: assert property (@(posedge bck) disable iff (!rst_n)
    !(led_i2s && led_sony));

  p_sony_needs_valid_r3: assert property (@(posedge bck) disable iff (!rst_n)
    fmt_sony |-> fmt_valid);

  p_rise_on_edge_r6: assert property (@(posedge bck) disable iff (!rst_n)
    $rose(fmt_valid) |-> ($past(ws_in) != $past(ws_in, 2)));

  p_flag_on_edge_r4: assert property (@(posedge bck) disable iff (!rst_n)
    (fmt_valid && $past(fmt_valid) && (fmt_sony != $past(fmt_sony)))
      |-> ($past(ws_in) != $past(ws_in, 2)));

  p_timeout_r7: assert property (@(posedge bck) disable iff (!rst_n)
    (idle > 10'd260) |-> !fmt_valid);
endmodule

bind fad_top fad_checker u_chk (.*);

// File: tb/tb_fad_top.sv
module tb_fad_top;
  localparam int PERIOD = 10;
  localparam int DLY    = 7;
  localparam int NVEC   = 6;
  // each row: half-frame length, number of WS transitions, exp valid, exp sony
  localparam int VEC [NVEC][4] = '{
    '{32, 3, 1, 0},   // R2: first edge + two 32 half-frames
    '{24, 2, 1, 0},   // R4: a single 24 half-frame does not switch
    '{24, 1, 1, 1},   // R3: second agreeing 24 switches to Sony
    '{40, 2, 1, 1},   // R5: unknown length keeps decision
    '{32, 2, 1, 1},   // R5: candidate restarted, no switch yet
    '{32, 1, 1, 0}    // R4: agreeing pair switches back
  };

  logic bck = 1'b0;
  logic rst_n;
  logic ws_in;
  logic data_in;
  logic fmt_valid, fmt_sony, led_i2s, led_sony, ws_out, data_out, bck_out;

  int checks = 0;
  int errors = 0;
  int n_edge = 0;
  logic hw [64];
  logic hd [64];

  fad_top dut (
    .bck(bck), .rst_n(rst_n), .ws_in(ws_in), .data_in(data_in),
    .fmt_valid(fmt_valid), .fmt_sony(fmt_sony), .led_i2s(led_i2s),
    .led_sony(led_sony), .ws_out(ws_out), .data_out(data_out),
    .bck_out(bck_out)
  );

  always #(PERIOD/2) bck = ~bck;

  always @(posedge bck) begin
    n_edge = n_edge + 1;
    hw[n_edge % 64] = ws_in;
    hd[n_edge % 64] = data_in;
  end

  initial begin
    data_in = 1'b0;
    forever begin
      @(negedge bck);
      data_in = 1'($urandom);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input string req, input int v, input int s);
    chk(req, int'(fmt_valid), v);
    chk(req, int'(fmt_sony), s);
    chk("R8", int'(led_i2s), v & ~s & 1);
    chk("R8", int'(led_sony), v & s);
  endtask

  task automatic chk_pipe(input int sony);
    int wtap;
    wtap = sony ? (2*DLY - 1) : (DLY - 1);
    chk("R9 data", int'(data_out), int'(hd[(n_edge - (DLY-1)) % 64]));
    chk("R9 ws", int'(ws_out), int'(hw[(n_edge - wtap) % 64]));
  endtask

  // toggles WS n times, holding each half-frame for len rising edges
  task automatic halves(input int len, input int n);
    for (int h = 0; h < n; h++) begin
      @(negedge bck);
      ws_in = ~ws_in;
      repeat (len) @(posedge bck);
    end
    #2;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    ws_in = 1'b0;
    repeat (3) @(posedge bck);
    @(negedge bck);
    rst_n = 1'b1;
    repeat (4) @(posedge bck);
  endtask

  initial begin
    rst_n = 1'b0;
    ws_in = 1'b0;
    #(PERIOD*3 + 2);
    chk_flags("R1", 0, 0);
    chk("R1", int'(ws_out), 0);
    chk("R1", int'(data_out), 0);
    @(negedge bck);
    rst_n = 1'b1;
    repeat (4) @(posedge bck);

    for (int i = 0; i < NVEC; i++) begin
      halves(VEC[i][0], VEC[i][1]);
      chk_flags((VEC[i][3] != 0) ? "R3/R4/R5 vec" : "R2/R4/R5 vec",
                VEC[i][2], VEC[i][3]);
      chk_pipe(VEC[i][3]);
    end

    // R10: forwarded clock, sampled 2 after a rising edge
    chk("R10", int'(bck_out), 1);
    @(negedge bck); #2;
    chk("R10", int'(bck_out), 0);

    // R7: last edge is 33 edges back here; cross the 256 limit
    repeat (199) @(posedge bck); #2;
    chk_flags("R7 before limit", 1, 0);
    repeat (40) @(posedge bck); #2;
    chk_flags("R7 after limit", 0, 0);
    chk_pipe(0);
    halves(24, 2);
    chk_flags("R7 reacquire pending", 0, 0);
    halves(24, 1);
    chk_flags("R7 reacquired", 1, 1);
    chk_pipe(1);

    // R1: asynchronous clear
    @(negedge bck); #1;
    rst_n = 1'b0;
    #1;
    chk_flags("R1 async", 0, 0);

    // R6: exact decision edge after a fresh reset
    do_reset();
    halves(24, 2);
    @(negedge bck);
    ws_in = ~ws_in;
    #1;
    chk("R6 before edge", int'(fmt_valid), 0);
    @(posedge bck); #2;
    chk("R6 after edge", int'(fmt_valid), 1);
    chk("R6 after edge", int'(fmt_sony), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule